// File: doc/BRIEF.md
# Multiword DMA Host Transfer Engine

This block sits on the host side of a True IDE disk-style bus and runs multiword DMA bursts of 16-bit words. Software-facing logic pulses `start` with a direction, a timing mode (0 to 2) and a word count. The engine then watches the device's request line, asserts the acknowledge, and toggles the read or write strobe once per word. Every strobe-high and strobe-low interval is stretched to whole clock cycles that meet the minimum times of the chosen mode.

On the host side, words come from a valid/ready source stream (device writes) or go to a valid/ready sink stream (device reads). A burst pauses between words when the device drops its request, when the host raises `pause`, when the source has no word to give, or when the sink still holds an unaccepted word. In each of these cases the word already on the bus finishes, the acknowledge is released, and the burst picks up again once the blocking condition clears. When the programmed count is used up, the acknowledge drops and `done` pulses.

Top module: `mdma_host_engine`

## Requirements
- R1: After reset, `dev_ack`, `dev_rd_stb`, `dev_wr_stb`, `busy`, `done` and `snk_valid` are all low.
- R2: Each strobe stays high for ceil(ns/CLK_NS) cycles of the mode's minimum active width: 215 ns, 80 ns or 70 ns for modes 0, 1 and 2. Mode value 3 uses the mode 0 timing. With CLK_NS=20 this gives 11, 4 and 4 cycles.
- R3: Consecutive strobes within one acknowledge are spaced so that the low time covers the negated minimum (read 50/50/25 ns, write 215/50/25 ns), the rise-to-rise time covers the cycle minimum (480/150/120 ns), and the acknowledge stays up at least 20/5/5 ns after the last fall. With CLK_NS=20 an unbroken burst strobes every 24, 8 or 6 cycles.
- R4: A strobe is only ever high while `dev_ack` is high. The two strobes are never high together. `dir_wr`=1 uses only the write strobe and `dir_wr`=0 uses only the read strobe.
- R5: On a write burst, each strobe consumes one source word, in stream order. That word sits on `dev_wdata` with `dev_wdata_oe` high for the whole strobe.
- R6: On a read burst, `dev_rdata` is sampled at the clock edge that ends the strobe. It is offered on `snk_data` with `snk_valid` held, unchanged, until `snk_ready`. Words reach the sink in bus order.
- R7: If `dev_req` is low when the next word would start, the current word completes and `dev_ack` drops. No further strobe occurs until `dev_req` is high again, and then the burst resumes.
- R8: Raising `pause` suspends the burst in the same way as R7, and lowering it resumes the burst.
- R9: A write burst waits, with acknowledge released, while `src_valid` is low. A read burst waits, with acknowledge released, while an earlier word is still unaccepted by the sink.
- R10: A burst makes exactly `word_count` strobes. `done` then pulses for one cycle with `dev_ack` and `busy` low. A count of zero pulses `done` with no strobe at all.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (accepted only when idle) |
| dir_wr | input | 1 | 1: host to device, 0: device to host |
| mode | input | 2 | Timing mode 0..2 (3 treated as 0) |
| word_count | input | CNT_W | Words in the burst |
| pause | input | 1 | Host request to suspend between words |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst completion |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Source word taken this cycle |
| snk_valid | output | 1 | Read word available to sink |
| snk_data | output | DW | Read word |
| snk_ready | input | 1 | Sink accepts word |
| dev_req | input | 1 | Device DMA request, active high |
| dev_ack | output | 1 | Host DMA acknowledge, active high |
| dev_rd_stb | output | 1 | Read strobe, active high |
| dev_wr_stb | output | 1 | Write strobe, active high |
| dev_wdata | output | DW | Write data to device |
| dev_wdata_oe | output | 1 | Write data drive enable |
| dev_rdata | input | DW | Read data from device |

## Verification
The hardest case to reach is a suspension that lands in the middle of a word, with the word already on the bus. The stimulus drops the request line or raises the pause input as soon as a chosen strobe is seen rising. The bench then confirms three things: that strobe completes, the acknowledge falls, and no further strobe appears until the condition clears. Read back-pressure follows the same pattern: the sink is held not-ready while the first captured word waits. Timing is checked by measuring every strobe's high time and its rise-to-rise spacing against values worked out from the nanosecond minimums.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACT  = 2'd2,
    ST_REC  = 2'd3
  } mdma_state_t;

  // Minimum times in ns; mode 3 falls back to the slowest set.
  function automatic int strobe_on_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 80;
      2'd2:    return 70;
      default: return 215;
    endcase
  endfunction

  function automatic int cycle_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 150;
      2'd2:    return 120;
      default: return 480;
    endcase
  endfunction

  function automatic int strobe_off_ns(input logic [1:0] m, input logic wr);
    case (m)
      2'd1:    return 50;
      2'd2:    return 25;
      default: return wr ? 215 : 50;
    endcase
  endfunction

  function automatic int ack_hold_ns(input logic [1:0] m);
    case (m)
      2'd1, 2'd2: return 5;
      default:    return 20;
    endcase
  endfunction

  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/mdma_timing.sv
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 20,
  parameter int TMR_W  = 8
) (
  input  logic [1:0]       mode_q,
  input  logic             dir_q,
  output logic [TMR_W-1:0] act_cyc,
  output logic [TMR_W-1:0] rec_cyc
);
  int a_c, off_c, cyc_c, hold_c, rest_c, r_c;

  always_comb begin
    a_c    = ns_to_cycles(strobe_on_ns(mode_q), CLK_NS);
    off_c  = ns_to_cycles(strobe_off_ns(mode_q, dir_q), CLK_NS);
    cyc_c  = ns_to_cycles(cycle_ns(mode_q), CLK_NS);
    hold_c = ns_to_cycles(ack_hold_ns(mode_q), CLK_NS);
    rest_c = (cyc_c > a_c) ? (cyc_c - a_c) : 0;
    r_c    = off_c;
    if (rest_c > r_c) r_c = rest_c;
    if (hold_c > r_c) r_c = hold_c;
    act_cyc = TMR_W'(a_c);
    rec_cyc = TMR_W'(r_c);
  end
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic [CNT_W-1:0] word_count,
  input  logic             can_go,
  input  logic [TMR_W-1:0] act_cyc,
  input  logic [TMR_W-1:0] rec_cyc,
  output mdma_state_t      st,
  output logic             launch,
  output logic             word_end,
  output logic             done
);
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] remain;
  logic             rec_last;

  assign rec_last = (st == ST_REC) && (tmr == '0);
  assign word_end = (st == ST_ACT) && (tmr == '0);
  assign launch   = ((st == ST_WAIT) && can_go) ||
                    (rec_last && (remain != '0) && can_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_acc) begin
            if (word_count == '0) done <= 1'b1;
            else begin
              remain <= word_count;
              st     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (launch) begin
            st  <= ST_ACT;
            tmr <= act_cyc - 1'b1;
          end
        end
        ST_ACT: begin
          if (word_end) begin
            st     <= ST_REC;
            tmr    <= rec_cyc - 1'b1;
            remain <= remain - 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        default: begin
          if (!rec_last) tmr <= tmr - 1'b1;
          else if (remain == '0) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else if (launch) begin
            st  <= ST_ACT;
            tmr <= act_cyc - 1'b1;
          end else st <= ST_WAIT;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdma_dpath.sv
module mdma_dpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_q,
  input  logic          launch,
  input  logic          word_end,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] dev_rdata,
  input  logic          snk_ready,
  output logic [DW-1:0] wdata,
  output logic          full,
  output logic [DW-1:0] snk_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata    <= '0;
      full     <= 1'b0;
      snk_data <= '0;
    end else begin
      if (launch && dir_q) wdata <= src_data;
      if (word_end && !dir_q) begin
        snk_data <= dev_rdata;
        full     <= 1'b1;
      end else if (full && snk_ready) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
  import mdma_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CNT_W  = 16,
  parameter int CLK_NS = 20,
  parameter int TMR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] word_count,
  input  logic             pause,
  output logic             busy,
  output logic             done,
  input  logic             src_valid,
  input  logic [DW-1:0]    src_data,
  output logic             src_ready,
  output logic             snk_valid,
  output logic [DW-1:0]    snk_data,
  input  logic             snk_ready,
  input  logic             dev_req,
  output logic             dev_ack,
  output logic             dev_rd_stb,
  output logic             dev_wr_stb,
  output logic [DW-1:0]    dev_wdata,
  output logic             dev_wdata_oe,
  input  logic [DW-1:0]    dev_rdata
);
  mdma_state_t      st;
  logic             dir_q, start_acc, launch, word_end, full, can_go, avail;
  logic [1:0]       mode_q;
  logic [TMR_W-1:0] act_cyc, rec_cyc;

  assign start_acc = start && (st == ST_IDLE);
  assign avail     = dir_q ? src_valid : !full;
  assign can_go    = dev_req && !pause && avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      mode_q <= 2'd0;
    end else if (start_acc) begin
      dir_q  <= dir_wr;
      mode_q <= mode;
    end
  end

  mdma_timing #(.CLK_NS(CLK_NS), .TMR_W(TMR_W)) u_timing (
    .mode_q(mode_q), .dir_q(dir_q), .act_cyc(act_cyc), .rec_cyc(rec_cyc)
  );

  mdma_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .word_count(word_count),
    .can_go(can_go), .act_cyc(act_cyc), .rec_cyc(rec_cyc), .st(st),
    .launch(launch), .word_end(word_end), .done(done)
  );

  mdma_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .launch(launch),
    .word_end(word_end), .src_data(src_data), .dev_rdata(dev_rdata),
    .snk_ready(snk_ready), .wdata(dev_wdata), .full(full), .snk_data(snk_data)
  );

  assign busy         = (st != ST_IDLE);
  assign dev_ack      = (st == ST_ACT) || (st == ST_REC);
  assign dev_rd_stb   = (st == ST_ACT) && !dir_q;
  assign dev_wr_stb   = (st == ST_ACT) && dir_q;
  assign dev_wdata_oe = dev_ack && dir_q;
  assign src_ready    = launch && dir_q;
  assign snk_valid    = full;
endmodule

// File: rtl/mdma_host_chk.sv
module mdma_host_chk
  import mdma_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CLK_NS = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_ack,
  input logic          dev_rd_stb,
  input logic          dev_wr_stb,
  input logic          dev_wdata_oe,
  input logic          done,
  input logic          busy,
  input logic          snk_valid,
  input logic          snk_ready,
  input logic [DW-1:0] dev_wdata,
  input logic [DW-1:0] snk_data,
  input logic [1:0]    mode_q,
  input logic          dir_q
);
  logic        stb, stb_q, seen;
  logic [15:0] hi_run, hi_last, lo_run;

  assign stb = dev_rd_stb | dev_wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0; seen <= 1'b0;
      hi_run <= '0; hi_last <= '0; lo_run <= '0;
    end else begin
      stb_q <= stb;
      if (stb) hi_run <= stb_q ? hi_run + 16'd1 : 16'd1;
      if (stb_q && !stb) hi_last <= hi_run;
      if (stb) lo_run <= '0;
      else if (lo_run != 16'hFFFF) lo_run <= lo_run + 16'd1;
      if (!dev_ack) seen <= 1'b0;
      else if (stb_q && !stb) seen <= 1'b1;
    end
  end

  // R2: strobe high time meets the mode minimum
  a_r2_on_width: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !stb) |-> (int'(hi_run) * CLK_NS >= strobe_on_ns(mode_q)));

  // R3: low time and full cycle between strobes of one acknowledge
  a_r3_off_width: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !stb_q && seen) |->
      ((int'(lo_run) * CLK_NS >= strobe_off_ns(mode_q, dir_q)) &&
       ((int'(hi_last) + int'(lo_run)) * CLK_NS >= cycle_ns(mode_q))));

  // R3: acknowledge held after the last strobe
  a_r3_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_ack) |-> (int'(lo_run) * CLK_NS >= ack_hold_ns(mode_q)));

  // R4: strobes only inside acknowledge, never both
  a_r4_stb_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> dev_ack);
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd_stb && dev_wr_stb));

  // R5: write word driven and steady through the strobe
  a_r5_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_stb && stb_q) |-> ($stable(dev_wdata) && dev_wdata_oe));

  // R6: sink word held until taken
  a_r6_snk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

  // R10: completion pulse only with the bus released
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dev_ack && !busy));
endmodule

bind mdma_host_engine mdma_host_chk #(.DW(DW), .CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_ack(dev_ack), .dev_rd_stb(dev_rd_stb),
  .dev_wr_stb(dev_wr_stb), .dev_wdata_oe(dev_wdata_oe), .done(done),
  .busy(busy), .snk_valid(snk_valid), .snk_ready(snk_ready),
  .dev_wdata(dev_wdata), .snk_data(snk_data), .mode_q(mode_q), .dir_q(dir_q)
);

// File: tb/mdma_host_engine_tb.sv
module mdma_host_engine_tb_top;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int CLK_NS = 20;
  localparam int MAXS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, dir_wr = 0, pause = 0, src_en = 0, snk_ready = 0, dev_req = 0;
  logic [1:0] mode = 0;
  logic [CW-1:0] word_count = 0;
  logic busy, done, src_ready, snk_valid, dev_ack, dev_rd_stb, dev_wr_stb, dev_wdata_oe;
  logic [DW-1:0] snk_data, dev_wdata, src_data, dev_rdata;

  int n_checks = 0, n_bad = 0, cycles = 0;
  int n_stb = 0, n_rd = 0, n_w = 0, n_r = 0, n_done = 0, n_viol = 0;
  int src_idx = 0, rd_idx = 0, hi_cnt = 0, per_cnt = 0;
  logic pstb = 0, chain = 0;
  int hiw [MAXS];
  int perw [MAXS];
  logic [DW-1:0] wcap [MAXS];
  logic [DW-1:0] rcap [MAXS];

  always #(CLK_NS/2) clk = ~clk;

  assign src_data  = 16'h1000 + 16'(src_idx);
  assign dev_rdata = 16'h8000 + 16'(rd_idx);

  mdma_host_engine #(.DW(DW), .CNT_W(CW), .CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .mode(mode),
    .word_count(word_count), .pause(pause), .busy(busy), .done(done),
    .src_valid(src_en), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_rd_stb(dev_rd_stb),
    .dev_wr_stb(dev_wr_stb), .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe),
    .dev_rdata(dev_rdata)
  );

  // Bus monitor and device / stream models, all at the falling edge.
  always @(negedge clk) begin
    logic s;
    s = dev_rd_stb | dev_wr_stb;
    per_cnt = per_cnt + 1;
    if (!dev_ack) chain = 0;
    if (dev_rd_stb && dev_wr_stb) n_viol = n_viol + 1;
    if (s && !dev_ack) n_viol = n_viol + 1;
    if (s && !pstb && n_stb < MAXS) begin
      perw[n_stb] = chain ? per_cnt : 0;
      per_cnt = 0; chain = 1;
      if (dev_wr_stb) begin
        wcap[n_w] = dev_wdata; n_w = n_w + 1; src_idx = src_idx + 1;
      end else begin
        n_rd = n_rd + 1; rd_idx = rd_idx + 1;
      end
      n_stb = n_stb + 1;
    end
    if (s) hi_cnt = hi_cnt + 1;
    if (!s && pstb) begin hiw[n_stb-1] = hi_cnt; hi_cnt = 0; end
    pstb = s;
    if (snk_valid && snk_ready && n_r < MAXS) begin rcap[n_r] = snk_data; n_r = n_r + 1; end
    if (done) n_done = n_done + 1;
  end

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int exp_on(input int m);
    return (m == 1) ? cdiv(80) : (m == 2) ? cdiv(70) : cdiv(215);
  endfunction
  function automatic int exp_per(input int m, input bit wr);
    int cyc, off, hold, p;
    cyc  = (m == 1) ? cdiv(150) : (m == 2) ? cdiv(120) : cdiv(480);
    off  = (m == 1) ? cdiv(50) : (m == 2) ? cdiv(25) : (wr ? cdiv(215) : cdiv(50));
    hold = (m == 1 || m == 2) ? cdiv(5) : cdiv(20);
    p = cyc;
    if (exp_on(m) + off > p) p = exp_on(m) + off;
    if (exp_on(m) + hold > p) p = exp_on(m) + hold;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic kick(input bit wr, input int m, input int n);
    dir_wr = wr; mode = 2'(m); word_count = CW'(n); start = 1;
    step(1);
    start = 0;
  endtask

  task automatic wait_done(input int d0);
    int k;
    k = 0;
    while (n_done == d0 && k < 4000) begin step(1); k = k + 1; end
    step(1);
  endtask

  task automatic check_widths(input int s0, input int n, input int m, input bit wr, input string tag);
    int bad_on, bad_per;
    bad_on = 0; bad_per = 0;
    for (int k = s0; k < s0 + n; k++) begin
      if (hiw[k] != exp_on(m)) bad_on = bad_on + 1;
      if (k > s0 && perw[k] != 0 && perw[k] != exp_per(m, wr)) bad_per = bad_per + 1;
    end
    check(bad_on == 0, {tag, " R2 strobe width"}, hiw[s0], exp_on(m));
    check(bad_per == 0, {tag, " R3 strobe spacing"}, (n > 1) ? perw[s0+1] : 0, exp_per(m, wr));
  endtask

  task automatic test_reset();
    check(!dev_ack && !dev_rd_stb && !dev_wr_stb && !busy && !done && !snk_valid,
          "R1 reset outputs", int'(dev_ack) + int'(busy) + int'(snk_valid), 0);
  endtask

  task automatic test_write_burst(input int m, input int n, input bit gapless);
    int s0, w0, i0, d0, rd0, v0, bad;
    s0 = n_stb; w0 = n_w; i0 = src_idx; d0 = n_done; rd0 = n_rd; v0 = n_viol;
    src_en = 1; dev_req = 1; pause = 0;
    kick(1, m, n);
    wait_done(d0);
    check(n_stb - s0 == n, "R10 write strobe count", n_stb - s0, n);
    bad = 0;
    for (int k = 0; k < n; k++) if (wcap[w0+k] != 16'h1000 + 16'(i0 + k)) bad = bad + 1;
    check(bad == 0, "R5 write word order", int'(wcap[w0]), int'(16'h1000 + 16'(i0)));
    check(n_rd == rd0 && n_viol == v0, "R4 write uses write strobe in ack", n_rd - rd0 + n_viol - v0, 0);
    if (gapless) check_widths(s0, n, m, 1'b1, "write");
    check(!dev_ack && !busy && n_done == d0 + 1, "R10 done and release", n_done - d0, 1);
  endtask

  task automatic test_read_burst(input int m, input int n);
    int s0, r0, i0, d0, bad;
    s0 = n_stb; r0 = n_r; i0 = rd_idx; d0 = n_done;
    snk_ready = 1; dev_req = 1; pause = 0;
    kick(0, m, n);
    wait_done(d0);
    step(2);
    check(n_stb - s0 == n, "R10 read strobe count", n_stb - s0, n);
    bad = 0;
    for (int k = 0; k < n; k++) if (rcap[r0+k] != 16'h8000 + 16'(i0 + k + 1)) bad = bad + 1;
    check(bad == 0 && n_r - r0 == n, "R6 read capture order", int'(rcap[r0]), int'(16'h8000 + 16'(i0 + 1)));
    check_widths(s0, n, m, 1'b0, "read");
  endtask

  task automatic test_dev_suspend();
    int s0, d0, k;
    s0 = n_stb; d0 = n_done; k = 0;
    src_en = 1; dev_req = 1;
    kick(1, 1, 6);
    while (n_stb - s0 < 2 && k < 500) begin step(1); k = k + 1; end
    dev_req = 0;
    step(30);
    check(n_stb - s0 == 2 && !dev_ack, "R7 device drop suspends after current word", n_stb - s0, 2);
    dev_req = 1;
    wait_done(d0);
    check(n_stb - s0 == 6, "R7 resume completes burst", n_stb - s0, 6);
  endtask

  task automatic test_host_pause();
    int s0, d0, r0, i0, k, bad;
    s0 = n_stb; d0 = n_done; r0 = n_r; i0 = rd_idx; k = 0;
    snk_ready = 1; dev_req = 1; pause = 0;
    kick(0, 2, 5);
    while (n_stb - s0 < 3 && k < 500) begin step(1); k = k + 1; end
    pause = 1;
    step(30);
    check(n_stb - s0 == 3 && !dev_ack, "R8 pause suspends", n_stb - s0, 3);
    pause = 0;
    wait_done(d0);
    step(2);
    bad = 0;
    for (int j = 0; j < 5; j++) if (rcap[r0+j] != 16'h8000 + 16'(i0 + j + 1)) bad = bad + 1;
    check(n_stb - s0 == 5 && bad == 0, "R8 resume after pause", n_stb - s0, 5);
  endtask

  task automatic test_sink_stall();
    int s0, d0, i0;
    s0 = n_stb; d0 = n_done; i0 = rd_idx;
    snk_ready = 0; dev_req = 1;
    kick(0, 2, 3);
    step(30);
    check(n_stb - s0 == 1 && !dev_ack, "R9 read stalls on full sink", n_stb - s0, 1);
    check(snk_valid && snk_data == 16'h8000 + 16'(i0 + 1), "R6 word held for sink",
          int'(snk_data), int'(16'h8000 + 16'(i0 + 1)));
    snk_ready = 1;
    wait_done(d0);
    check(n_stb - s0 == 3, "R9 read resumes", n_stb - s0, 3);
  endtask

  task automatic test_src_starve();
    int s0, d0;
    s0 = n_stb; d0 = n_done;
    src_en = 0; dev_req = 1;
    kick(1, 2, 2);
    step(20);
    check(n_stb == s0 && !dev_ack && busy, "R9 write waits for source", n_stb - s0, 0);
    src_en = 1;
    wait_done(d0);
    check(n_stb - s0 == 2, "R9 write resumes", n_stb - s0, 2);
  endtask

  task automatic test_zero_count();
    int s0, d0;
    s0 = n_stb; d0 = n_done;
    kick(1, 0, 0);
    step(3);
    check(n_done == d0 + 1 && n_stb == s0 && !busy, "R10 zero count", n_done - d0, 1);
  endtask

  task automatic test_start_ignored();
    int s0, d0, rd0, k;
    s0 = n_stb; d0 = n_done; rd0 = n_rd; k = 0;
    src_en = 1; dev_req = 1;
    kick(1, 2, 4);
    while (n_stb - s0 < 1 && k < 100) begin step(1); k = k + 1; end
    dir_wr = 0; word_count = 9; start = 1; step(1); start = 0;
    wait_done(d0);
    step(40);
    check(n_stb - s0 == 4 && n_rd == rd0 && n_done == d0 + 1, "R11 start ignored when busy",
          n_stb - s0, 4);
  endtask

  initial begin
    step(5);
    rst_n = 1;
    step(2);
    test_reset();
    test_write_burst(0, 3, 1'b1);
    test_write_burst(1, 5, 1'b1);
    test_write_burst(2, 6, 1'b1);
    test_read_burst(0, 3);
    test_read_burst(1, 4);
    test_read_burst(2, 6);
    test_write_burst(3, 2, 1'b1);
    test_dev_suspend();
    test_host_pause();
    test_sink_stall();
    test_src_starve();
    test_zero_count();
    test_start_ignored();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles = cycles + 1; end
    n_checks = n_checks + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule